// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Timer

This block times every power-switch cycle of a peak-current-controlled flyback or buck-boost stage. Each cycle starts with the gate going high. For a fixed window after turn-on, the current-sense comparator is ignored. The gate turns off when that comparator reports the peak current, but never before a minimum on-time has elapsed and never after a maximum on-time. After turn-off, the zero-current comparator is ignored for a blanking window. The block then waits for the auxiliary winding voltage to drop below its threshold and starts the next cycle in that valley.

The control loop supplies a requested minimum period. The block clamps this request between a floor of 5 µs and a ceiling of about 166.7 µs, and never starts a new cycle before the clamped period has run. If no zero-current event arrives, the ceiling forces the next cycle to start. The block reports the time from turn-off to the zero-current event, in clock cycles, as a measurement for the loop. An enable input gates all switching. All time windows are given in nanoseconds and converted to clock cycles from a clock-frequency parameter, which defaults to 100 MHz.

Top module: `qr_cycle_timer`

## Requirements
- R1: During and after reset, `gate` and `demag_vld` are low. The first cycle starts on the clock edge that samples `en` high, so `gate` is high one cycle after `en` rises.
- R2: `pk_trip` is ignored while the count of on-cycles is below LEB (55 cycles by default). A trip pulse that falls entirely inside this window leaves the gate on for the maximum on-time.
- R3: A trip accepted before the minimum on-time has elapsed is remembered. The gate then stays high for exactly MIN_ON cycles (55 by default).
- R4: A trip accepted at on-cycle index k, where k ≥ MIN_ON−1, leaves the gate high for k+1 cycles. Index 0 is the first cycle the gate is high.
- R5: Without an accepted trip, the gate stays high for exactly MAX_ON cycles (1280 by default).
- R6: `zcd_low` is ignored during the first ZB off-cycles after turn-off (200 by default).
- R7: If the minimum period has already elapsed, a `zcd_low` accepted at off-cycle index o starts the next cycle one clock later. The period from gate rise to gate rise is then on-time + o + 1 cycles.
- R8: A new cycle never starts earlier than max(`per_req`, MIN_PER) cycles after the previous gate rise. MIN_PER is 500 cycles by default. A request above MAX_PER is treated as MAX_PER.
- R9: If no zero-current event is accepted, the next cycle starts MAX_PER cycles after the previous gate rise (16666 cycles by default).
- R10: The first accepted zero-current event of a cycle raises `demag_vld` for one clock cycle, one cycle after acceptance. In that cycle `demag_time` holds the off-cycle index at which the event was accepted.
- R11: `en` low during an on-time turns the gate off on the next clock edge. No cycle starts while `en` is low. When `en` goes high after the maximum period has expired, a cycle starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Switching enable |
| pk_trip | input | 1 | Peak current comparator, high when the sensed current exceeds the peak target |
| zcd_low | input | 1 | Zero-current comparator, high when the auxiliary voltage is below threshold |
| per_req | input | PER_W | Requested minimum period in clock cycles |
| gate | output | 1 | Registered gate drive |
| demag_time | output | PER_W | Measured turn-off to zero-current time in clock cycles |
| demag_vld | output | 1 | One-cycle strobe marking a new `demag_time` |

## Verification
Each switching cycle is driven with a chosen trip position and length, a chosen window for the zero-current input, and a period request. Trips placed inside blanking, between blanking and the minimum on-time, and after the minimum on-time separate the blanking, deferral and normal turn-off paths. Zero-current windows that lie only inside the blanking window, start before it ends, or start well after it separate blanked events, clipped valleys and free valleys. Period requests below the floor, between the limits and above the ceiling show whether the period is set by the valley, by the request, by the floor or by the forced maximum.

// File: rtl/qr_pkg.sv
package qr_pkg;
  typedef enum logic {PH_OFF = 1'b0, PH_ON = 1'b1} phase_e;

  // converts a duration in ns to whole clock cycles (truncating)
  function automatic int ns2cyc(input int ns, input int mhz);
    return (ns * mhz) / 1000;
  endfunction
endpackage

// File: rtl/qr_on_timer.sv
module qr_on_timer #(
  parameter int LEB_CYC    = 55,
  parameter int MIN_ON_CYC = 55,
  parameter int MAX_ON_CYC = 1280,
  parameter int ON_W       = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic on_phase,
  input  logic en,
  input  logic pk_trip,
  output logic off_req
);
  localparam logic [ON_W-1:0] LEB_V   = ON_W'(LEB_CYC);
  localparam logic [ON_W-1:0] MINON_V = ON_W'(MIN_ON_CYC - 1);
  localparam logic [ON_W-1:0] MAXON_V = ON_W'(MAX_ON_CYC - 1);

  logic [ON_W-1:0] on_cnt;
  logic            trip_pend;
  logic            trip_now;
  logic            armed;

  assign trip_now = on_phase && pk_trip && (on_cnt >= LEB_V);
  assign armed    = trip_pend || trip_now;
  assign off_req  = on_phase && (!en || (armed && on_cnt >= MINON_V) || on_cnt == MAXON_V);

  always_ff @(posedge clk) begin
    if (rst || !on_phase) begin
      on_cnt    <= '0;
      trip_pend <= 1'b0;
    end else begin
      if (on_cnt != MAXON_V) on_cnt <= on_cnt + 1'b1;
      trip_pend <= armed;
    end
  end

  // R5
  on_cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    on_phase |-> on_cnt <= MAXON_V);

  // R3
  min_on_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (on_phase && en && on_cnt < MINON_V) |-> !off_req);

  // R2
  blank_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (on_phase && on_cnt < LEB_V) |=> !trip_pend);
endmodule

// File: rtl/qr_off_timer.sv
module qr_off_timer #(
  parameter int ZB_CYC = 200,
  parameter int PER_W  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             off_phase,
  input  logic             zcd_low,
  output logic             zcd_hit,
  output logic             zcd_seen,
  output logic [PER_W-1:0] demag_time,
  output logic             demag_vld
);
  localparam logic [PER_W-1:0] ZB_V = PER_W'(ZB_CYC);

  logic [PER_W-1:0] off_cnt;

  assign zcd_hit = off_phase && !zcd_seen && zcd_low && (off_cnt >= ZB_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_cnt    <= '0;
      zcd_seen   <= 1'b0;
      demag_time <= '0;
      demag_vld  <= 1'b0;
    end else begin
      demag_vld <= zcd_hit;
      if (zcd_hit) demag_time <= off_cnt;
      if (!off_phase) begin
        off_cnt  <= '0;
        zcd_seen <= 1'b0;
      end else begin
        if (off_cnt != '1) off_cnt <= off_cnt + 1'b1;
        if (zcd_hit) zcd_seen <= 1'b1;
      end
    end
  end

  // R6
  demag_floor_chk: assert property (@(posedge clk) disable iff (rst)
    demag_vld |-> demag_time >= ZB_V);

  // R10
  demag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    demag_vld |=> !demag_vld);
endmodule

// File: rtl/qr_period_timer.sv
module qr_period_timer #(
  parameter int MIN_PER_CYC = 500,
  parameter int MAX_PER_CYC = 16666,
  parameter int PER_W       = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PER_W-1:0] per_req,
  output logic             min_ok,
  output logic             max_hit
);
  localparam logic [PER_W-1:0] MINP_V = PER_W'(MIN_PER_CYC);
  localparam logic [PER_W-1:0] MAXP_V = PER_W'(MAX_PER_CYC);

  logic [PER_W-1:0] per_cnt;
  logic [PER_W-1:0] eff_min;

  always_comb begin
    if (per_req < MINP_V)      eff_min = MINP_V;
    else if (per_req > MAXP_V) eff_min = MAXP_V;
    else                       eff_min = per_req;
  end

  assign min_ok  = per_cnt >= (eff_min - 1'b1);
  assign max_hit = per_cnt == (MAXP_V - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)                             per_cnt <= MAXP_V - 1'b1;
    else if (start)                      per_cnt <= '0;
    else if (per_cnt != MAXP_V - 1'b1)   per_cnt <= per_cnt + 1'b1;
  end

  // R9
  per_cap_chk: assert property (@(posedge clk) disable iff (rst)
    per_cnt <= MAXP_V - 1'b1);

  // R8
  start_floor_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> per_cnt >= MINP_V - 1'b1);
endmodule

// File: rtl/qr_cycle_timer.sv
module qr_cycle_timer
  import qr_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int LEB_NS       = 550,
  parameter int MIN_ON_NS    = 550,
  parameter int MAX_ON_NS    = 12800,
  parameter int ZCD_BLANK_NS = 2000,
  parameter int MIN_PER_NS   = 5000,
  parameter int MAX_PER_NS   = 166667,
  localparam int MAX_PER_CYC = ns2cyc(MAX_PER_NS, CLK_MHZ),
  localparam int PER_W       = $clog2(MAX_PER_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pk_trip,
  input  logic             zcd_low,
  input  logic [PER_W-1:0] per_req,
  output logic             gate,
  output logic [PER_W-1:0] demag_time,
  output logic             demag_vld
);
  localparam int LEB_CYC     = ns2cyc(LEB_NS, CLK_MHZ);
  localparam int MIN_ON_CYC  = ns2cyc(MIN_ON_NS, CLK_MHZ);
  localparam int MAX_ON_CYC  = ns2cyc(MAX_ON_NS, CLK_MHZ);
  localparam int ZB_CYC      = ns2cyc(ZCD_BLANK_NS, CLK_MHZ);
  localparam int MIN_PER_CYC = ns2cyc(MIN_PER_NS, CLK_MHZ);
  localparam int ON_W        = $clog2(MAX_ON_CYC + 1);

  phase_e phase_q;
  logic   off_req, zcd_hit, zcd_seen, min_ok, max_hit, start;

  assign start = (phase_q == PH_OFF) && en && min_ok && (zcd_seen || zcd_hit || max_hit);

  always_ff @(posedge clk) begin
    if (rst)                                phase_q <= PH_OFF;
    else if (phase_q == PH_ON && off_req)   phase_q <= PH_OFF;
    else if (start)                         phase_q <= PH_ON;
  end

  assign gate = (phase_q == PH_ON);

  qr_on_timer #(
    .LEB_CYC(LEB_CYC), .MIN_ON_CYC(MIN_ON_CYC), .MAX_ON_CYC(MAX_ON_CYC), .ON_W(ON_W)
  ) u_on (
    .clk(clk), .rst(rst), .on_phase(phase_q == PH_ON), .en(en),
    .pk_trip(pk_trip), .off_req(off_req)
  );

  qr_off_timer #(.ZB_CYC(ZB_CYC), .PER_W(PER_W)) u_off (
    .clk(clk), .rst(rst), .off_phase(phase_q == PH_OFF), .zcd_low(zcd_low),
    .zcd_hit(zcd_hit), .zcd_seen(zcd_seen), .demag_time(demag_time), .demag_vld(demag_vld)
  );

  qr_period_timer #(
    .MIN_PER_CYC(MIN_PER_CYC), .MAX_PER_CYC(MAX_PER_CYC), .PER_W(PER_W)
  ) u_per (
    .clk(clk), .rst(rst), .start(start), .per_req(per_req),
    .min_ok(min_ok), .max_hit(max_hit)
  );

  // R11
  en_low_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !gate);

  // R1
  gate_rise_en_chk: assert property (@(posedge clk) disable iff (rst)
    (!gate && !en) |=> !gate);

  // R7
  valley_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!gate && zcd_hit && min_ok && en) |=> gate);
endmodule

// File: tb/sim_qr_cycle_timer.sv
module sim_qr_cycle_timer;
  localparam int CLK_MHZ = 100;
  localparam int LEB     = 200 * CLK_MHZ / 1000;     // overridden blanking: 20 cycles
  localparam int MINON   = 550 * CLK_MHZ / 1000;
  localparam int MAXON   = 12800 * CLK_MHZ / 1000;
  localparam int ZB      = 2000 * CLK_MHZ / 1000;
  localparam int MINP    = 5000 * CLK_MHZ / 1000;
  localparam int MAXP    = 166667 * CLK_MHZ / 1000;
  localparam int PW      = $clog2(MAXP + 1);
  localparam int BIG     = 1 << 30;

  // trip_at, trip_len, zcd_at, zcd_end, per_req
  localparam int NV = 8;
  localparam int VT [0:NV-1][0:4] = '{
    '{100, 1000, 300, BIG, 0},      // R4 R7 R10
    '{30,  1,    250, BIG, 0},      // R3
    '{5,   10,   0,   BIG, 0},      // R2 R5 R6
    '{60,  5,    400, BIG, 2000},   // R8
    '{200, 1000, 10,  50,  0},      // R6 R9
    '{100, 1000, 220, BIG, 100},    // R8 floor
    '{300, 5,    700, BIG, 0},      // R7
    '{100, 1000, 300, BIG, 20000}   // R8 clamp R9
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, en, pk, zcd;
  logic [PW-1:0] req;
  logic gate, dv;
  logic [PW-1:0] dt;
  int n_chk = 0, n_fail = 0;

  qr_cycle_timer #(.CLK_MHZ(CLK_MHZ), .LEB_NS(200)) u0 (
    .clk(clk), .rst(rst), .en(en), .pk_trip(pk), .zcd_low(zcd), .per_req(req),
    .gate(gate), .demag_time(dt), .demag_vld(dv)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int exp_on(input int ta, input int tl);
    int acc, off;
    if (ta + tl - 1 < LEB) return MAXON;
    acc = imax(ta, LEB);
    off = imax(acc, MINON - 1);
    return (off > MAXON - 1) ? MAXON : off + 1;
  endfunction

  function automatic int exp_zacc(input int za, input int ze);
    int a = imax(za, ZB);
    return (a < ze) ? a : -1;
  endfunction

  // entered at the first negedge where gate is high; leaves at the next one
  task automatic run_cycle(input int ta, input int tl, input int za, input int ze, input int r,
                           output int on_len, output int per, output int dmo, output bit dseen);
    int t = 0;
    int o = 0;
    req = PW'(r);
    dseen = 1'b0;
    dmo = 0;
    while (gate) begin
      pk = (t >= ta) && (t < ta + tl);
      t++;
      @(negedge clk);
    end
    pk = 1'b0;
    on_len = t;
    while (!gate) begin
      if (dv) begin dseen = 1'b1; dmo = int'(dt); end
      zcd = (o >= za) && (o < ze);
      o++;
      @(negedge clk);
    end
    if (dv) begin dseen = 1'b1; dmo = int'(dt); end
    zcd = 1'b0;
    per = on_len + o;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (R1) actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int on_len, per, dmo, ex_on, za, ex_per, pmin;
    bit dseen;
    int highs;
    rst = 1'b1; en = 1'b0; pk = 1'b0; zcd = 1'b0; req = '0;
    repeat (5) @(negedge clk);
    check(gate == 1'b0, "R1 gate in reset", int'(gate), 0);
    check(dv == 1'b0, "R1 demag_vld in reset", int'(dv), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(gate == 1'b0, "R11 no start with en low", int'(gate), 0);
    en = 1'b1;
    @(negedge clk);
    check(gate == 1'b1, "R1 first cycle after en", int'(gate), 1);

    for (int i = 0; i < NV; i++) begin
      run_cycle(VT[i][0], VT[i][1], VT[i][2], VT[i][3], VT[i][4], on_len, per, dmo, dseen);
      ex_on = exp_on(VT[i][0], VT[i][1]);
      za = exp_zacc(VT[i][2], VT[i][3]);
      pmin = VT[i][4] < MINP ? MINP : (VT[i][4] > MAXP ? MAXP : VT[i][4]);
      if (za >= 0 && ex_on + za + 1 <= MAXP) ex_per = imax(pmin, ex_on + za + 1);
      else begin ex_per = MAXP; za = -1; end
      check(on_len == ex_on, $sformatf("vec%0d on-time R2 R3 R4 R5", i), on_len, ex_on);
      check(per == ex_per, $sformatf("vec%0d period R6 R7 R8 R9", i), per, ex_per);
      if (za >= 0) begin
        check(dseen && dmo == za, $sformatf("vec%0d demag time R10", i), dmo, za);
      end else begin
        check(!dseen, $sformatf("vec%0d no demag strobe R6 R10", i), int'(dseen), 0);
      end
    end

    // R11: en dropped mid on-time, then held low past the maximum period
    repeat (10) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(gate == 1'b0, "R11 gate off after en drop", int'(gate), 0);
    highs = 0;
    for (int k = 0; k < MAXP + 200; k++) begin
      @(negedge clk);
      if (gate) highs++;
    end
    check(highs == 0, "R11 no cycle while en low", highs, 0);
    en = 1'b1;
    @(negedge clk);
    check(gate == 1'b1, "R11 restart once en high", int'(gate), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule